// File: doc/BRIEF.md
# Mode Timing List Parser

This block walks a video mode definition held in memory as consecutive 32-bit words. On a start pulse it latches a base byte address and fetches the words one at a time through a request/response read port. Only one read is in flight at any moment. The first word must hold the format code 3. If it holds anything else, parsing stops at once with an error. The next fifteen words are captured into timing and flag registers.

The horizontal and vertical timing values are held in two six-entry arrays. Every word after the fixed header belongs to a trailing list of two-word control items. Each complete item is presented for one cycle on an output strobe.

The list ends only when the first word of an item is all-ones. An all-ones second word is ordinary data. The second word of an item is not requested until its first word has arrived and been checked. A completion pulse reports the result, and an error flag goes with it. The error flag stays set until the next accepted start.

Top module: `mode_list_parser`

## Requirements
- R1: After reset the block is idle: `busy`, `rd_req`, `done`, `error` and `item_valid` are all low, and no read is requested while idle.
- R2: If word 0 is not equal to 3, the block issues no further read. It pulses `done` with `error` high after exactly one read.
- R3: Words 1 to 15 are captured into fixed outputs: word 1 into `bpp_log2`, and words 2..7 into `h_timing[0..5]` (sync width, back porch, left border, active size, right border, front porch). Words 8..13 go into `v_timing[0..5]` in the same order, word 14 into `pixel_khz`, and word 15 into `sync_flags`.
- R4: Each control item (words 16+2k and 17+2k) appears on `item_first`/`item_second` with a `item_valid` pulse one cycle wide, in list order.
- R5: Read `n` of a run uses byte address `base_addr + 4*n`, and a new request is never issued while a read is outstanding.
- R6: Only the first word of an item is tested for the all-ones terminator. An all-ones second word is emitted as data and parsing continues.
- R7: The second word of an item is requested only after the first word has been received and found not to be the terminator. No word past the terminator is read.
- R8: If the first word of item number MAX_PAIRS+1 is not the terminator, the block ends with `error` high after emitting MAX_PAIRS items.
- R9: `done` is a single-cycle pulse, and `error` changes only at `done` or at an accepted start. A start asserted while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin parsing (accepted only while idle) |
| base_addr | input | 32 | Byte address of word 0 |
| busy | output | 1 | A parse is in progress |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 32 | Returned word |
| bpp_log2 | output | 32 | Log2 bits-per-pixel word |
| h_timing | output | 6x32 | Horizontal fields, index 0 = sync width .. 5 = front porch |
| v_timing | output | 6x32 | Vertical fields in rasters, same index order |
| pixel_khz | output | 32 | Pixel rate in kHz |
| sync_flags | output | 32 | Sync polarity and interlace flag word |
| item_valid | output | 1 | Control item present for one cycle |
| item_first | output | 32 | First word of the item |
| item_second | output | 32 | Second word of the item |
| done | output | 1 | Parse finished pulse |
| error | output | 1 | Bad format or missing terminator, held until next start |

## Verification
The bench places an all-ones value in a second word. A design that tests every word for the terminator would stop early, and would be short both items and reads. It also counts every read and records the address of the last one. A design that fetched a second word before checking the first, or read past the end, shows up as a wrong count or a wrong final address.

The limit on items is tested on both sides: exactly MAX_PAIRS items followed by a terminator, and a list with no terminator in range. An off-by-one limit either flags a good list or emits one item too many. A bad format word must cost exactly one read. A start pulse during a run must leave the results of that run unchanged.

// File: rtl/mode_list_parser.sv
module mode_list_parser #(
  parameter int MAX_PAIRS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      base_addr,
  output logic             busy,
  output logic             rd_req,
  output logic [31:0]      rd_addr,
  input  logic             rd_valid,
  input  logic [31:0]      rd_data,
  output logic [31:0]      bpp_log2,
  output logic [5:0][31:0] h_timing,
  output logic [5:0][31:0] v_timing,
  output logic [31:0]      pixel_khz,
  output logic [31:0]      sync_flags,
  output logic             item_valid,
  output logic [31:0]      item_first,
  output logic [31:0]      item_second,
  output logic             done,
  output logic             error
);
  localparam int IDX_W = $clog2(16 + 2*MAX_PAIRS + 2);
  localparam int PC_W  = $clog2(MAX_PAIRS + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;
  state_t           st;
  logic [IDX_W-1:0] idx;
  logic [PC_W-1:0]  pairs;
  logic [31:0]      base_q, first_q;

  assign busy    = (st != S_IDLE);
  assign rd_req  = (st == S_ISSUE);
  assign rd_addr = base_q + (32'(idx) << 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; pairs <= '0; base_q <= '0; first_q <= '0;
      bpp_log2 <= '0; h_timing <= '0; v_timing <= '0; pixel_khz <= '0; sync_flags <= '0;
      item_valid <= 1'b0; item_first <= '0; item_second <= '0;
      done <= 1'b0; error <= 1'b0;
    end else begin
      item_valid <= 1'b0;
      done       <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q <= base_addr; idx <= '0; pairs <= '0; error <= 1'b0;
          st <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        default: if (rd_valid) begin
          st  <= S_ISSUE;
          idx <= idx + 1'b1;
          if (idx == '0) begin
            if (rd_data != 32'd3) begin
              st <= S_IDLE; done <= 1'b1; error <= 1'b1;
            end
          end else if (idx < IDX_W'(16)) begin
            if (idx == IDX_W'(1))       bpp_log2 <= rd_data;
            else if (idx <= IDX_W'(7))  h_timing[3'(idx - IDX_W'(2))] <= rd_data;
            else if (idx <= IDX_W'(13)) v_timing[3'(idx - IDX_W'(8))] <= rd_data;
            else if (idx == IDX_W'(14)) pixel_khz <= rd_data;
            else                        sync_flags <= rd_data;
          end else if (!idx[0]) begin
            if (&rd_data) begin
              st <= S_IDLE; done <= 1'b1;
            end else if (pairs == PC_W'(MAX_PAIRS)) begin
              st <= S_IDLE; done <= 1'b1; error <= 1'b1;
            end else begin
              first_q <= rd_data;
            end
          end else begin
            item_valid  <= 1'b1;
            item_first  <= first_q;
            item_second <= rd_data;
            pairs       <= pairs + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mode_list_parser_chk.sv
module mode_list_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        rd_req,
  input logic [31:0] rd_addr,
  input logic        rd_valid,
  input logic        item_valid,
  input logic        done,
  input logic        error
);
  logic        pend, have_last;
  logic [31:0] last_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; have_last <= 1'b0; last_addr <= '0;
    end else begin
      if (rd_req) pend <= 1'b1;
      else if (rd_valid) pend <= 1'b0;
      if (start && !busy) have_last <= 1'b0;
      else if (rd_req) begin have_last <= 1'b1; last_addr <= rd_addr; end
    end
  end

  assert_idle_quiet_R1:       assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rd_req);
  assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> !pend);
  assert_addr_stride_R5:      assert property (@(posedge clk) disable iff (!rst_n) (rd_req && have_last) |-> rd_addr == last_addr + 32'd4);
  assert_item_pulse_R4:       assert property (@(posedge clk) disable iff (!rst_n) item_valid |=> !item_valid);
  assert_done_pulse_R9:       assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_error_with_done_R9:  assert property (@(posedge clk) disable iff (!rst_n) $rose(error) |-> done);
  assert_error_held_R9:       assert property (@(posedge clk) disable iff (!rst_n) (error && !(start && !busy)) |=> error);
endmodule

bind mode_list_parser mode_list_parser_chk u_chk (.*);

// File: tb/tb_mode_list_parser.sv
module tb_mode_list_parser;
  localparam int MAXP = 64;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] base_addr = '0;
  logic busy, rd_req, rd_valid, item_valid, done, error;
  logic [31:0] rd_addr, rd_data, bpp_log2, pixel_khz, sync_flags, item_first, item_second;
  logic [5:0][31:0] h_timing, v_timing;

  always #2 clk = ~clk;

  mode_list_parser #(.MAX_PAIRS(MAXP)) dut (.*);

  logic [31:0] mem [256];
  logic [31:0] run_base, paddr, last_req;
  int lat, cnt, nreq;
  logic pend;
  int checks = 0, fails = 0;
  logic [31:0] exp_f[$], exp_s[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual %h expected %h", req, act, exp); end
  endtask

  initial begin rd_valid = 1'b0; rd_data = '0; pend = 1'b0; nreq = 0; cnt = 0; end
  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      pend <= 1'b1; cnt <= lat; paddr <= rd_addr; nreq <= nreq + 1; last_req <= rd_addr;
    end else if (pend) begin
      if (cnt == 0) begin
        rd_valid <= 1'b1; rd_data <= mem[8'((paddr - run_base) >> 2)]; pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  always @(negedge clk) if (rst_n && item_valid) begin
    if (exp_f.size() == 0) chk(1'b0, "R4 extra item", item_first, 32'hx);
    else begin
      logic [31:0] ef, es;
      ef = exp_f.pop_front(); es = exp_s.pop_front();
      chk(item_first == ef, "R4 item first", item_first, ef);
      chk(item_second == es, "R6 item second", item_second, es);
    end
  end

  task automatic build(input int npairs, input bit term, input logic [31:0] fmt, input int seed);
    for (int k = 0; k < 256; k++) mem[k] = '0;
    mem[0] = fmt;
    for (int k = 1; k < 16; k++) mem[k] = 32'(seed * 256 + k);
    for (int i = 0; i < npairs; i++) begin
      mem[16 + 2*i] = 32'(seed << 16) | 32'(2*i + 1);
      mem[17 + 2*i] = (i == 1) ? 32'hFFFF_FFFF : 32'(seed << 16) | 32'(2*i + 2);
      if (fmt == 32'd3 && i < MAXP) begin
        exp_f.push_back(mem[16 + 2*i]); exp_s.push_back(mem[17 + 2*i]);
      end
    end
    if (term) mem[16 + 2*npairs] = 32'hFFFF_FFFF;
  endtask

  task automatic run(input string tag, input logic [31:0] base, input int latency,
                     input int exp_req, input bit exp_err, input int seed, input bit poke);
    run_base = base; lat = latency;
    @(negedge clk); nreq = 0; base_addr = base; start = 1'b1;
    @(negedge clk); start = 1'b0; base_addr = 32'hDEAD_0000;
    if (poke) begin repeat (20) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; end
    while (!done) @(negedge clk);
    chk(error == exp_err, {tag, " R2/R8 error"}, 32'(error), 32'(exp_err));
    chk(nreq == exp_req, {tag, " R7 read count"}, 32'(nreq), 32'(exp_req));
    chk(last_req == base + 32'(4*(exp_req-1)), {tag, " R5 last addr"}, last_req, base + 32'(4*(exp_req-1)));
    if (!exp_err || exp_req > 1) begin
      chk(bpp_log2 == 32'(seed*256+1), {tag, " R3 bpp"}, bpp_log2, 32'(seed*256+1));
      for (int j = 0; j < 6; j++) begin
        chk(h_timing[j] == 32'(seed*256+2+j), {tag, " R3 h"}, h_timing[j], 32'(seed*256+2+j));
        chk(v_timing[j] == 32'(seed*256+8+j), {tag, " R3 v"}, v_timing[j], 32'(seed*256+8+j));
      end
      chk(pixel_khz == 32'(seed*256+14), {tag, " R3 rate"}, pixel_khz, 32'(seed*256+14));
      chk(sync_flags == 32'(seed*256+15), {tag, " R3 flags"}, sync_flags, 32'(seed*256+15));
    end
    @(negedge clk);
    chk(!done, {tag, " R9 done pulse"}, 32'(done), 0);
    chk(exp_f.size() == 0, {tag, " R4 items left"}, 32'(exp_f.size()), 0);
    repeat (3) @(negedge clk);
    chk(error == exp_err, {tag, " R9 error held"}, 32'(error), 32'(exp_err));
    exp_f.delete(); exp_s.delete();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !done && !error && !item_valid, "R1 reset idle",
        {27'd0, busy, rd_req, done, error, item_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rd_req, "R1 no read idle", 32'(rd_req), 0);
    build(3, 1, 32'd3, 1);     run("three", 32'h0000_1000, 0, 16+7, 0, 1, 0);
    build(0, 1, 32'd3, 2);     run("empty", 32'h0004_0000, 2, 17, 0, 2, 0);
    build(2, 1, 32'd2, 3);     run("badfmt", 32'h0000_2000, 1, 1, 1, 3, 0);
    build(5, 1, 32'd3, 4);     run("poke", 32'h0000_3000, 1, 16+11, 0, 4, 1);
    build(MAXP, 1, 32'd3, 5);  run("atmax", 32'h0000_5000, 0, 16+2*MAXP+1, 0, 5, 0);
    build(MAXP+5, 0, 32'd3, 6); run("nosent", 32'h0000_6000, 0, 16+2*MAXP+1, 1, 6, 0);
    build(1, 1, 32'd3, 7);     run("clear", 32'h0000_7000, 3, 19, 0, 7, 0);
    finish_up();
  end
endmodule